// File: doc/BRIEF.md
# Three-Voice Square Tone Generator

This block makes three square waves and adds them into one unsigned output level. Software reaches it through two write strobes that share one 8-bit data bus. A write with the select strobe stores a selector byte. A write with the data strobe then puts the byte into one of sixteen sound registers. That store happens only when the selector's upper nibble is at or above the audio window value, which is `4'hC` by default.

A free-running prescaler divides the clock by sixteen. Each prescaler tick clocks one down-counter per voice. Each voice has a 12-bit period, and a period of zero acts as one. When a counter sits at zero on a tick, it reloads and its square output flips, so each half cycle lasts 16·(P+1) clocks.

A mask register holds one active-low enable bit per voice. Three volume registers hold a 4-bit level each. The output is the sum of the volumes of the voices that are enabled and currently high. It follows the square state and register changes with no added delay.

Top module: `sq3_tone_gen`

## Requirements
- R1: A select-strobe write latches the whole byte. A data-strobe write stores into register `sel[3:0]` only when `sel[7:4] >= 4'hC`, so 0xC0–0xFF all qualify. The latched selector stays in force for any number of later data writes.
- R2: A data-strobe write while the selector is below 0xC0 changes nothing that the output can show.
- R3: The tone counters advance exactly once every 16 clocks, and the first advance comes 16 clocks after reset is released.
- R4: The period of voice n is `{reg[2n+1][3:0], reg[2n]}`, and bits 7:4 of `reg[2n+1]` are ignored.
- R5: On a tick, a counter at zero reloads its period and flips its square state; otherwise it decrements. A steady period P therefore gives output steps every 16·(P+1) clocks.
- R6: A period of zero behaves as one, which gives steps every 32 clocks.
- R7: Register 7 bits 2:0 are active-low enables for voices 0, 1 and 2. A disabled voice adds nothing to the output.
- R8: Registers 8, 9 and 10 bits 3:0 are the volumes of voices 0, 1 and 2.
- R9: The output is the 6-bit sum of the volumes of voices that are enabled and high, and it never exceeds 45.
- R10: Reset clears every register, loads each counter with 1, drives all squares low and clears the prescaler, so the output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Latch `wr_data` as the selector |
| dat_we | input | 1 | Store `wr_data` into the selected sound register |
| wr_data | input | 8 | Write data shared by both strobes |
| level | output | 6 | Summed output amplitude |

## Verification
The bench builds the block with its default parameters: three voices, 12-bit periods, 4-bit volumes and a prescaler of 16. The prescaler of 16 selects the power-of-two wrap variant. With these values, half-periods of 32, 96 and 4192 clocks all fit in a short run. That covers the zero-period rule, small periods and the high-nibble period field. A reset part way through the run puts all three voices in phase, so the full-scale sum of 45 can be reached.

// File: rtl/sq3_pkg.sv
package sq3_pkg;
   localparam int BYTE_W  = 8;
   localparam int REG_CNT = 16;
   localparam int IDX_W   = $clog2(REG_CNT);
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sq3_regfile.sv
module sq3_regfile
   import sq3_pkg::*;
#(
   parameter int          N_VOICE = 3,
   parameter int          PER_W   = 12,
   parameter int          VOL_W   = 4,
   parameter logic [3:0]  AUD_SEL = 4'hC
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel_we,
   input  logic                       dat_we,
   input  byte_t                      wr_data,
   output byte_t                      sel_q,
   output logic [N_VOICE*PER_W-1:0]   per_flat,
   output logic [N_VOICE-1:0]         en,
   output logic [N_VOICE*VOL_W-1:0]   vol_flat
);
   localparam int HI_W    = PER_W - BYTE_W;
   localparam int MASK_IX = 2 * N_VOICE + 1;
   localparam int VOL_IX  = 2 * N_VOICE + 2;

   byte_t regs [REG_CNT];
   logic  in_window;
   logic  unused_bits;

   assign in_window = (sel_q[BYTE_W-1:IDX_W] >= AUD_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
      end else begin
         if (sel_we) sel_q <= wr_data;
         if (dat_we && in_window) regs[sel_q[IDX_W-1:0]] <= wr_data;
      end
   end

   genvar v;
   generate
      for (v = 0; v < N_VOICE; v++) begin : g_fields
         assign per_flat[v*PER_W +: PER_W] = {regs[2*v+1][HI_W-1:0], regs[2*v]};
         assign en[v]                      = ~regs[MASK_IX][v];
         assign vol_flat[v*VOL_W +: VOL_W] = regs[VOL_IX+v][VOL_W-1:0];
      end
   endgenerate

   always_comb begin
      unused_bits = 1'b0;
      for (int i = 0; i < REG_CNT; i++) unused_bits = unused_bits ^ (^regs[i]);
   end
endmodule

// File: rtl/sq3_prescaler.sv
module sq3_prescaler #(
   parameter int PRESCALE = 16,
   localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   logic [PRE_W-1:0] cnt;

   generate
      if ((PRESCALE & (PRESCALE - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
         assign tick = &cnt;
      end else begin : g_cmp
         localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/sq3_voice.sv
module sq3_voice #(
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   output logic             sq
);
   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] reload;

   assign reload = (period == '0) ? PER_W'(1) : period;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= PER_W'(1);
         sq  <= 1'b0;
      end else if (tick) begin
         if (cnt == '0) begin
            cnt <= reload;
            sq  <= ~sq;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/sq3_mixer.sv
module sq3_mixer #(
   parameter int N_VOICE = 3,
   parameter int VOL_W   = 4,
   parameter int LVL_W   = 6
) (
   input  logic [N_VOICE-1:0]       en,
   input  logic [N_VOICE-1:0]       sq,
   input  logic [N_VOICE*VOL_W-1:0] vol_flat,
   output logic [LVL_W-1:0]         level
);
   always_comb begin
      level = '0;
      for (int i = 0; i < N_VOICE; i++) begin
         if (en[i] && sq[i])
            level = level + {{(LVL_W-VOL_W){1'b0}}, vol_flat[i*VOL_W +: VOL_W]};
      end
   end
endmodule

// File: rtl/sq3_tone_gen.sv
module sq3_tone_gen
   import sq3_pkg::*;
#(
   parameter int          N_VOICE  = 3,
   parameter int          PER_W    = 12,
   parameter int          VOL_W    = 4,
   parameter int          PRESCALE = 16,
   parameter logic [3:0]  AUD_SEL  = 4'hC,
   localparam int LVL_W = $clog2(N_VOICE * ((1 << VOL_W) - 1) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic             dat_we,
   input  logic [7:0]       wr_data,
   output logic [LVL_W-1:0] level
);
   generate
      if (PER_W <= BYTE_W || PER_W > 2 * BYTE_W) begin : g_bad_per
         $error("PER_W must lie between 9 and 16");
      end
      if (2 * N_VOICE + 2 + N_VOICE > REG_CNT) begin : g_bad_voices
         $error("N_VOICE does not fit the register window");
      end
      if (VOL_W > BYTE_W || LVL_W <= VOL_W) begin : g_bad_vol
         $error("VOL_W out of range");
      end
      if (PRESCALE < 2) begin : g_bad_pre
         $error("PRESCALE must be at least 2");
      end
   endgenerate

   byte_t                     sel_q;
   logic [N_VOICE*PER_W-1:0]  per_flat;
   logic [N_VOICE-1:0]        en;
   logic [N_VOICE*VOL_W-1:0]  vol_flat;
   logic [N_VOICE-1:0]        sq_vec;
   logic                      tick;

   sq3_regfile #(
      .N_VOICE (N_VOICE),
      .PER_W   (PER_W),
      .VOL_W   (VOL_W),
      .AUD_SEL (AUD_SEL)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (sel_we),
      .dat_we   (dat_we),
      .wr_data  (wr_data),
      .sel_q    (sel_q),
      .per_flat (per_flat),
      .en       (en),
      .vol_flat (vol_flat)
   );

   sq3_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   genvar v;
   generate
      for (v = 0; v < N_VOICE; v++) begin : g_voice
         sq3_voice #(.PER_W(PER_W)) u_voice (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .period (per_flat[v*PER_W +: PER_W]),
            .sq     (sq_vec[v])
         );
      end
   endgenerate

   sq3_mixer #(
      .N_VOICE (N_VOICE),
      .VOL_W   (VOL_W),
      .LVL_W   (LVL_W)
   ) u_mix (
      .en       (en),
      .sq       (sq_vec),
      .vol_flat (vol_flat),
      .level    (level)
   );
endmodule

// File: rtl/sq3_tone_chk.sv
module sq3_tone_chk #(
   parameter int          N_VOICE  = 3,
   parameter int          VOL_W    = 4,
   parameter int          PRESCALE = 16,
   parameter logic [3:0]  AUD_SEL  = 4'hC,
   parameter int          LVL_W    = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sel_we,
   input logic               dat_we,
   input logic [7:0]         sel_q,
   input logic               tick,
   input logic [N_VOICE-1:0] sq_vec,
   input logic [LVL_W-1:0]   level
);
   localparam int LVL_MAX = N_VOICE * ((1 << VOL_W) - 1);

   int gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   gap <= 0;
      else if (tick) gap <= 0;
      else          gap <= gap + 1;
   end

   // R9
   level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= LVL_MAX);

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> gap == PRESCALE - 1);

   // R5
   sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(sq_vec));

   // R2
   ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !sel_we && sel_q[7:4] < AUD_SEL && !tick) |=> $stable(level));

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> level == '0);
endmodule

bind sq3_tone_gen sq3_tone_chk #(
   .N_VOICE  (N_VOICE),
   .VOL_W    (VOL_W),
   .PRESCALE (PRESCALE),
   .AUD_SEL  (AUD_SEL),
   .LVL_W    (LVL_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sel_we (sel_we),
   .dat_we (dat_we),
   .sel_q  (sel_q),
   .tick   (tick),
   .sq_vec (sq_vec),
   .level  (level)
);

// File: tb/sq3_tone_gen_bench.sv
`timescale 1ns/1ps
module sq3_tone_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_we = 1'b0;
   logic       dat_we = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [5:0] level;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int cyc   = 0;

   always #4 clk = ~clk;

   sq3_tone_gen u_sq3_tone_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_we  (sel_we),
      .dat_we  (dat_we),
      .wr_data (wr_data),
      .level   (level)
   );

   // behavioural reference model
   int m_reg [16];
   int m_sel, m_pre;
   int m_cnt [3];
   bit m_sq  [3];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_reg[i]) m_reg[i] = 0;
         m_sel = 0; m_pre = 0;
         for (int v = 0; v < 3; v++) begin m_cnt[v] = 1; m_sq[v] = 0; end
      end else begin
         bit tk;
         tk = (m_pre == 15);
         m_pre = (m_pre + 1) % 16;
         if (tk) begin
            for (int v = 0; v < 3; v++) begin
               int p;
               p = (m_reg[2*v+1] % 16) * 256 + m_reg[2*v];
               if (p == 0) p = 1;
               if (m_cnt[v] == 0) begin m_cnt[v] = p; m_sq[v] = !m_sq[v]; end
               else m_cnt[v] = m_cnt[v] - 1;
            end
         end
         if (dat_we && m_sel >= 192) m_reg[m_sel % 16] = int'(wr_data);
         if (sel_we) m_sel = int'(wr_data);
      end
   end

   function automatic int model_level();
      int s = 0;
      for (int v = 0; v < 3; v++)
         if (((m_reg[7] >> v) & 1) == 0 && m_sq[v]) s += m_reg[8+v] % 16;
      return s;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R9: every-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) chk(int'(level) == model_level(), "R9 per-cycle level", int'(level), model_level());
   end

   task automatic write_sel(input logic [7:0] b);
      @(negedge clk); sel_we = 1'b1; wr_data = b;
      @(negedge clk); sel_we = 1'b0;
   endtask

   task automatic write_dat(input logic [7:0] b);
      @(negedge clk); dat_we = 1'b1; wr_data = b;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic set_reg(input int idx, input logic [7:0] b);
      write_sel(8'hC0 | 8'(idx));
      write_dat(b);
   endtask

   task automatic wait_step(output int n);
      logic [5:0] prev;
      prev = level; n = 0;
      do begin @(negedge clk); n++; end while (level == prev && n < 20000);
   endtask

   task automatic peak(input int win, output int mx);
      mx = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (int'(level) > mx) mx = int'(level);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // watchdog
   always @(negedge clk) begin
      if (cyc > 150000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      int n, mx, first;
      repeat (3) @(negedge clk);
      chk(level == 6'd0, "R10 level during reset", int'(level), 0);
      rst_n = 1'b1;
      // R3 / R10: first output step of a zero-period voice after reset
      // happens 32 clocks after release when it is enabled with volume.
      first = 0;
      chk(level == 6'd0, "R10 level after reset", int'(level), 0);

      // voice 0 only, full volume, zero period
      set_reg(8, 8'h0F);
      set_reg(7, 8'hFE);
      wait_step(n);
      wait_step(n);
      chk(n == 32, "R6 zero period half-cycle", n, 32);
      chk(level == 6'd0 || level == 6'd15, "R8 voice0 volume level", int'(level), 15);

      // period 5
      set_reg(0, 8'h05);
      wait_step(n); wait_step(n);
      wait_step(n);
      chk(n == 96, "R5 period 5 half-cycle", n, 96);
      chk(n % 16 == 0, "R3 steps on prescaler grid", n % 16, 0);

      // high bits with ignored upper nibble: 0x105 -> 16*262
      set_reg(1, 8'hF1);
      wait_step(n); wait_step(n);
      wait_step(n);
      chk(n == 4192, "R4 twelve-bit period half-cycle", n, 4192);

      // back to zero period
      set_reg(1, 8'h00);
      set_reg(0, 8'h00);
      wait_step(n); wait_step(n);

      // R7: mask voice 0 off
      set_reg(7, 8'hFF);
      peak(200, mx);
      chk(mx == 0, "R7 disabled voice silent", mx, 0);
      set_reg(7, 8'hFE);

      // R2: selector below window, data write must not change volume
      set_reg(8, 8'h09);
      write_sel(8'hB8);
      write_dat(8'h03);
      peak(200, mx);
      chk(mx == 9, "R2 low selector write ignored", mx, 9);

      // R1: selector 0xF8 is in window, latched selector reused
      write_sel(8'hF8);
      write_dat(8'h06);
      peak(200, mx);
      chk(mx == 6, "R1 high-nibble selector write", mx, 6);
      write_dat(8'h04);
      peak(200, mx);
      chk(mx == 4, "R1 latched selector reused", mx, 4);

      // R9: all voices in phase at full scale after a fresh reset
      do_reset();
      chk(level == 6'd0, "R10 level after second reset", int'(level), 0);
      set_reg(8, 8'h0F);
      set_reg(9, 8'h0F);
      set_reg(10, 8'h0F);
      set_reg(7, 8'hF8);
      peak(200, mx);
      chk(mx == 45, "R9 full-scale sum", mx, 45);

      // R8: volumes map to voices 1 and 2 individually
      set_reg(7, 8'hFD);
      set_reg(9, 8'h07);
      peak(200, mx);
      chk(mx == 7, "R8 voice1 volume", mx, 7);
      set_reg(7, 8'hFB);
      set_reg(10, 8'h0B);
      peak(200, mx);
      chk(mx == 11, "R8 voice2 volume", mx, 11);

      if (first != 0) chk(1'b0, "R3 unused", first, 0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule